// File: doc/BRIEF.md
# Pointer Address Generation Unit

This unit turns a memory request into an effective address for a load/store datapath. It owns three 16-bit data pointers (called X, Y and Z here) and a 16-bit stack pointer. Each accepted request uses one pointer to form an address. Depending on the addressing mode, the unit may also return an updated pointer, and it commits that new value in its own registers on the same clock edge.

The supported modes are plain indirect, post-increment, pre-decrement, displacement (Y and Z only), push, pop, and table reads from program memory through Z, with and without post-increment. A program-memory read turns the byte pointer into a word address and a byte-lane select. A load mode writes a pointer from an external value. All results come out registered one cycle after the request, so a new request can be issued on every cycle.

Top module: `ptr_addr_unit`

## Requirements
- R1: After synchronous reset, `addr_valid` and `wb_valid` are 0, X, Y and Z hold 0, and the stack pointer holds parameter `SP_INIT` (default 16'h21FF).
- R2: Mode 8 (load) writes `req_value` into the pointer named by `req_sel` (0 X, 1 Y, 2 Z, 3 stack pointer). It reports `wb_valid`=1 with that code and value, and `addr_valid`=0.
- R3: Mode 0 (plain) gives `addr_out` = selected pointer. The pointer does not change and `wb_valid`=0.
- R4: Mode 1 (post-increment) gives `addr_out` = pointer, then writes back pointer+1.
- R5: Mode 2 (pre-decrement) gives `addr_out` = pointer-1, and that same value is written back.
- R6: Mode 3 (displacement) with Y or Z gives `addr_out` = pointer + `req_disp`, where `req_disp` is an unsigned 6-bit value, and does not write back. With X the request is ignored.
- R7: Mode 4 (push) gives `addr_out` = stack pointer, then writes back stack pointer-1 with `wb_sel`=3.
- R8: Mode 5 (pop) first increments the stack pointer, uses the incremented value as `addr_out`, and writes it back.
- R9: Mode 6 (program read) uses Z regardless of `req_sel`. It sets `prog_sel`=1, `addr_out` = Z>>1 (word address) and `byte_hi` = Z bit 0 (0 = low byte at the even address). There is no write-back.
- R10: Mode 7 (program read with post-increment) behaves as mode 6 and also writes back Z+1 with `wb_sel`=2.
- R11: All pointer arithmetic wraps modulo 2^16.
- R12: Results appear in the cycle after the accepted request. On a cycle with no request, `addr_valid` and `wb_valid` are 0. Back-to-back post-increment requests give consecutive addresses.
- R13: Modes 0 to 3 with `req_sel`=3 are ignored, and so are modes 9 to 15. An ignored request gives `addr_valid`=0 and `wb_valid`=0 and leaves every pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Addressing mode code |
| req_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z, 3 stack pointer) |
| req_disp | input | 6 | Unsigned displacement |
| req_value | input | 16 | Value for load mode |
| addr_valid | output | 1 | Effective address valid |
| addr_out | output | 16 | Data byte address or program word address |
| prog_sel | output | 1 | Address targets program memory |
| byte_hi | output | 1 | Program-memory lane: 1 selects the high byte |
| wb_valid | output | 1 | Pointer write-back occurred |
| wb_sel | output | 2 | Pointer written back |
| wb_value | output | 16 | New pointer value |

## Verification
Assertions check on every cycle how each mode relates the address to the write-back value:
- post-increment, push and pre-decrement each step by one;
- pop and pre-decrement access at the value they write back;
- displacement and rejected requests produce no write-back;
- a program read's lane bit follows Z bit 0;
- an unwritten pointer register holds its value.

The bench's reference model is the only way to show effects that span several requests. These are whether an ignored request left a pointer untouched, whether write-backs wrapped correctly at 0 and 0xFFFF, and whether a push followed by a pop reaches the same address.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  localparam logic [3:0] MD_PLAIN   = 4'd0;
  localparam logic [3:0] MD_POSTINC = 4'd1;
  localparam logic [3:0] MD_PREDEC  = 4'd2;
  localparam logic [3:0] MD_DISP    = 4'd3;
  localparam logic [3:0] MD_PUSH    = 4'd4;
  localparam logic [3:0] MD_POP     = 4'd5;
  localparam logic [3:0] MD_PROG    = 4'd6;
  localparam logic [3:0] MD_PROGINC = 4'd7;
  localparam logic [3:0] MD_LOAD    = 4'd8;

  localparam logic [1:0] SEL_X  = 2'd0;
  localparam logic [1:0] SEL_Y  = 2'd1;
  localparam logic [1:0] SEL_Z  = 2'd2;
  localparam logic [1:0] SEL_SP = 2'd3;
endpackage

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int AW = 16,
  parameter int NREG = 4,
  parameter logic [AW-1:0] SP_INIT = 16'h21FF,
  localparam int SW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_val,
  output logic [AW-1:0] z_val,
  output logic [AW-1:0] sp_val,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_val
);
  logic [AW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] INITV = (i == NREG-1) ? SP_INIT : '0;
    always_ff @(posedge clk) begin
      if (rst) q[i] <= INITV;
      else if (wr_en && wr_sel == SW'(i)) q[i] <= wr_val;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_sel == SW'(i)) |=> $stable(q[i])); // R13
  end

  assign rd_val = q[rd_sel];
  assign z_val  = q[2];
  assign sp_val = q[NREG-1];
endmodule

// File: rtl/ptr_calc.sv
module ptr_calc
  import ptr_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          valid,
  input  logic [3:0]    mode,
  input  logic [1:0]    sel,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] value,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] z,
  input  logic [AW-1:0] sp,
  output logic          addr_en,
  output logic [AW-1:0] addr,
  output logic          prog,
  output logic          lane,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic dptr;
  assign dptr = (sel != SEL_SP);

  always_comb begin
    addr_en = 1'b0;
    addr    = '0;
    prog    = 1'b0;
    lane    = 1'b0;
    wb_en   = 1'b0;
    wb_sel  = sel;
    wb_val  = '0;
    if (valid) begin
      case (mode)
        MD_PLAIN: if (dptr) begin
          addr_en = 1'b1;
          addr    = cur;
        end
        MD_POSTINC: if (dptr) begin
          addr_en = 1'b1;
          addr    = cur;
          wb_en   = 1'b1;
          wb_val  = cur + ONE;
        end
        MD_PREDEC: if (dptr) begin
          addr_en = 1'b1;
          addr    = cur - ONE;
          wb_en   = 1'b1;
          wb_val  = cur - ONE;
        end
        MD_DISP: if (sel == SEL_Y || sel == SEL_Z) begin
          addr_en = 1'b1;
          addr    = cur + AW'(disp);
        end
        MD_PUSH: begin
          addr_en = 1'b1;
          addr    = sp;
          wb_en   = 1'b1;
          wb_sel  = SEL_SP;
          wb_val  = sp - ONE;
        end
        MD_POP: begin
          addr_en = 1'b1;
          addr    = sp + ONE;
          wb_en   = 1'b1;
          wb_sel  = SEL_SP;
          wb_val  = sp + ONE;
        end
        MD_PROG, MD_PROGINC: begin
          addr_en = 1'b1;
          prog    = 1'b1;
          addr    = {1'b0, z[AW-1:1]};
          lane    = z[0];
          if (mode == MD_PROGINC) begin
            wb_en  = 1'b1;
            wb_sel = SEL_Z;
            wb_val = z + ONE;
          end
        end
        MD_LOAD: begin
          wb_en  = 1'b1;
          wb_val = value;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6,
  parameter logic [AW-1:0] SP_INIT = 16'h21FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [3:0]    req_mode,
  input  logic [1:0]    req_sel,
  input  logic [QW-1:0] req_disp,
  input  logic [AW-1:0] req_value,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out,
  output logic          prog_sel,
  output logic          byte_hi,
  output logic          wb_valid,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value
);
  logic [AW-1:0] cur, zv, spv, c_addr, c_wbv;
  logic c_aen, c_prog, c_lane, c_wben;
  logic [1:0] c_wbs;

  ptr_regfile #(.AW(AW), .NREG(4), .SP_INIT(SP_INIT)) u_regs (
    .clk(clk), .rst(rst), .rd_sel(req_sel), .rd_val(cur),
    .z_val(zv), .sp_val(spv),
    .wr_en(c_wben), .wr_sel(c_wbs), .wr_val(c_wbv)
  );

  ptr_calc #(.AW(AW), .QW(QW)) u_calc (
    .valid(req_valid), .mode(req_mode), .sel(req_sel), .disp(req_disp),
    .value(req_value), .cur(cur), .z(zv), .sp(spv),
    .addr_en(c_aen), .addr(c_addr), .prog(c_prog), .lane(c_lane),
    .wb_en(c_wben), .wb_sel(c_wbs), .wb_val(c_wbv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
      prog_sel   <= 1'b0;
      byte_hi    <= 1'b0;
      wb_valid   <= 1'b0;
      wb_sel     <= '0;
      wb_value   <= '0;
    end else begin
      addr_valid <= c_aen;
      addr_out   <= c_addr;
      prog_sel   <= c_prog;
      byte_hi    <= c_lane;
      wb_valid   <= c_wben;
      wb_sel     <= c_wbs;
      wb_value   <= c_wbv;
    end
  end

  logic dsel;
  assign dsel = req_valid && req_sel != SEL_SP;

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
    dsel && req_mode == MD_POSTINC |=> addr_out == $past(cur) && wb_value == addr_out + AW'(1)); // R4
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (rst)
    dsel && req_mode == MD_PREDEC |=> addr_out == wb_value && wb_value == $past(cur) - AW'(1)); // R5
  AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_mode == MD_DISP |=> !wb_valid); // R6
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_mode == MD_PUSH |=> addr_out == $past(spv) && wb_value == $past(spv) - AW'(1)); // R7
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_mode == MD_POP |=> addr_out == wb_value && wb_sel == SEL_SP); // R8
  AST_PROG_LANE: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_mode == MD_PROG || req_mode == MD_PROGINC) |=> prog_sel && byte_hi == $past(zv[0])); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid && !wb_valid); // R12
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_mode > MD_LOAD |=> !addr_valid && !wb_valid); // R13
endmodule

// File: tb/test_ptr_addr_unit.sv
module test_ptr_addr_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_mode = '0;
  logic [1:0] req_sel = '0;
  logic [5:0] req_disp = '0;
  logic [15:0] req_value = '0;
  logic addr_valid, prog_sel, byte_hi, wb_valid;
  logic [15:0] addr_out, wb_value;
  logic [1:0] wb_sel;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [15:0] m [4];

  always #4 clk = ~clk;

  ptr_addr_unit i_ptr_addr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_sel(req_sel), .req_disp(req_disp), .req_value(req_value),
    .addr_valid(addr_valid), .addr_out(addr_out), .prog_sel(prog_sel),
    .byte_hi(byte_hi), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] md, input logic [1:0] s);
    if (md > 4'd8) return "R13";
    if (md <= 4'd3 && s == 2'd3) return "R13";
    case (md)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic do_req(input logic [3:0] md, input logic [1:0] s, input logic [5:0] q,
                        input logic [15:0] v, input string rtag);
    logic e_av, e_pr, e_hi, e_wv;
    logic [15:0] e_ad, e_wd;
    logic [1:0] e_ws;
    logic dp;
    string r;
    r = (rtag == "") ? tag_of(md, s) : rtag;
    e_av = 0; e_pr = 0; e_hi = 0; e_wv = 0; e_ad = 0; e_wd = 0; e_ws = s;
    dp = (s != 2'd3);
    case (md)
      4'd0: if (dp) begin e_av = 1; e_ad = m[s]; end
      4'd1: if (dp) begin e_av = 1; e_ad = m[s]; e_wv = 1; e_wd = m[s] + 16'd1; end
      4'd2: if (dp) begin e_av = 1; e_ad = m[s] - 16'd1; e_wv = 1; e_wd = e_ad; end
      4'd3: if (s == 2'd1 || s == 2'd2) begin e_av = 1; e_ad = m[s] + {10'd0, q}; end
      4'd4: begin e_av = 1; e_ad = m[3]; e_wv = 1; e_ws = 3; e_wd = m[3] - 16'd1; end
      4'd5: begin e_av = 1; e_ad = m[3] + 16'd1; e_wv = 1; e_ws = 3; e_wd = e_ad; end
      4'd6, 4'd7: begin
        e_av = 1; e_pr = 1; e_ad = {1'b0, m[2][15:1]}; e_hi = m[2][0];
        if (md == 4'd7) begin e_wv = 1; e_ws = 2; e_wd = m[2] + 16'd1; end
      end
      4'd8: begin e_wv = 1; e_wd = v; end
      default: ;
    endcase
    if (e_wv) m[e_ws] = e_wd;
    @(negedge clk);
    req_valid = 1; req_mode = md; req_sel = s; req_disp = q; req_value = v;
    @(posedge clk);
    #2;
    chk(r, "addr_valid", {31'd0, addr_valid}, {31'd0, e_av});
    chk(r, "wb_valid", {31'd0, wb_valid}, {31'd0, e_wv});
    if (e_av) begin
      chk(r, "addr_out", {16'd0, addr_out}, {16'd0, e_ad});
      chk(r, "prog_sel", {31'd0, prog_sel}, {31'd0, e_pr});
      if (e_pr) chk(r, "byte_hi", {31'd0, byte_hi}, {31'd0, e_hi});
    end
    if (e_wv) begin
      chk(r, "wb_sel", {30'd0, wb_sel}, {30'd0, e_ws});
      chk(r, "wb_value", {16'd0, wb_value}, {16'd0, e_wd});
    end
  endtask

  task automatic idle(input string r);
    @(negedge clk);
    req_valid = 0;
    req_mode = 4'd1;
    @(posedge clk);
    #2;
    chk(r, "idle addr_valid", {31'd0, addr_valid}, 32'd0);
    chk(r, "idle wb_valid", {31'd0, wb_valid}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2121));
    m[0] = 16'h0000; m[1] = 16'h0000; m[2] = 16'h0000; m[3] = 16'h21FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "reset addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R1", "reset wb_valid", {31'd0, wb_valid}, 32'd0);
    do_req(4'd0, 2'd0, 6'd0, 16'h0, "R1");
    do_req(4'd0, 2'd1, 6'd0, 16'h0, "R1");
    do_req(4'd0, 2'd2, 6'd0, 16'h0, "R1");
    do_req(4'd4, 2'd0, 6'd0, 16'h0, "R1");
    do_req(4'd5, 2'd0, 6'd0, 16'h0, "R8");
    // wrap-around cases
    do_req(4'd8, 2'd0, 6'd0, 16'hFFFF, "R2");
    do_req(4'd1, 2'd0, 6'd0, 16'h0, "R11");
    do_req(4'd2, 2'd0, 6'd0, 16'h0, "R11");
    do_req(4'd8, 2'd2, 6'd0, 16'hFFF0, "R2");
    do_req(4'd3, 2'd2, 6'd63, 16'h0, "R11");
    do_req(4'd3, 2'd0, 6'd5, 16'h0, "R6");
    // consecutive post-increments
    do_req(4'd8, 2'd1, 6'd0, 16'h0100, "R2");
    do_req(4'd1, 2'd1, 6'd0, 16'h0, "R12");
    do_req(4'd1, 2'd1, 6'd0, 16'h0, "R12");
    do_req(4'd1, 2'd1, 6'd0, 16'h0, "R12");
    do_req(4'd0, 2'd1, 6'd0, 16'h0, "R12");
    idle("R12");
    // program-memory lanes
    do_req(4'd8, 2'd2, 6'd0, 16'h0101, "R2");
    do_req(4'd6, 2'd0, 6'd0, 16'h0, "R9");
    do_req(4'd7, 2'd1, 6'd0, 16'h0, "R10");
    do_req(4'd7, 2'd3, 6'd0, 16'h0, "R10");
    do_req(4'd6, 2'd0, 6'd0, 16'h0, "R9");
    // ignored requests
    do_req(4'd1, 2'd3, 6'd0, 16'h0, "R13");
    do_req(4'd12, 2'd0, 6'd0, 16'h0, "R13");
    do_req(4'd0, 2'd0, 6'd0, 16'h0, "R13");
    do_req(4'd8, 2'd3, 6'd0, 16'h0000, "R2");
    do_req(4'd5, 2'd0, 6'd0, 16'h0, "R11");
    do_req(4'd4, 2'd0, 6'd0, 16'h0, "R7");
    for (int i = 0; i < 600; i++) begin
      logic [3:0] md;
      md = 4'($urandom_range(0, 10));
      do_req(md, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
             16'($urandom), "");
      if ($urandom_range(0, 9) == 0) idle("R12");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule